// File: doc/BRIEF.md
# OSD Display Window Position Timer

This block derives the raster position of an on-screen-display window from the incoming video sync signals. A horizontal counter measures OSD dot clocks from the start of each line, and a vertical counter measures scan lines from the start of each field. Both sync inputs pass through a two-flop synchroniser, and each has its own polarity control bit. The block compares the counters with two 6-bit start-position settings. It reports whether the current dot and line lie inside the window, flags the first column and the first line of the window, and gives the offsets from the window origin. A character generator downstream uses these outputs to fetch and place glyph dots.

The horizontal counter runs only while the synchronised horizontal sync sits at its programmed active level. It runs only on cycles where the dot-clock enable is high, and it clears as soon as the sync leaves that level. The vertical counter steps once for every new horizontal sync pulse and clears while the vertical sync is active. The window begins 4·HPOS+5 dot clocks into the line and 4·VPOS lines into the field. Both counters saturate rather than wrap.

Top module: `osd_window_timer`

## Requirements
- R1: Each sync input passes through two flops before use: a level change driven just before clock edge k is first seen by the counters at edge k+2, so the horizontal counter still advances at edge k+1.
- R2: While synchronised horizontal sync is at its active level, the horizontal count rises by one on every clock edge with `dot_en` high. At and after the window start, `hx` equals count minus start.
- R3: The horizontal window start is 4·`hpos`+5. `h_active` is 1 exactly when the count is at or above the start, and `h_first` is 1 exactly when the count equals it.
- R4: An `hpos` value below 10 is treated as 10, which gives a start of 45.
- R5: While synchronised horizontal sync is inactive, the horizontal count is held at zero, and `h_active`, `h_first` and `hx` are 0.
- R6: `hsync_act_hi`=1 makes a high `hsync_in` active, and 0 makes a low one active. `vsync_act_hi` does the same for `vsync_in`.
- R7: The vertical count rises by one for each transition of synchronised horizontal sync into its active level. The vertical start is 4·`vpos`. `v_active` is count ≥ start, `v_first` is count = start, and `vy` is count minus start (0 outside the window).
- R8: While synchronised vertical sync is active, the vertical count is held at zero, and `v_active`, `v_first` and `vy` are 0.
- R9: A clock edge with `dot_en` low leaves the horizontal count unchanged.
- R10: Both counters stop at their all-ones value instead of wrapping.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | OSD dot-clock enable (one dot per enabled cycle) |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hsync_act_hi | input | 1 | 1: horizontal sync active high; 0: active low |
| vsync_act_hi | input | 1 | 1: vertical sync active high; 0: active low |
| hpos | input | HPOS_W | Horizontal start setting |
| vpos | input | VPOS_W | Vertical start setting |
| h_active | output | 1 | Current dot inside the horizontal window |
| h_first | output | 1 | Current dot is the first window column |
| hx | output | HCNT_W | Dot offset from the window start |
| v_active | output | 1 | Current line inside the vertical window |
| v_first | output | 1 | Current line is the first window line |
| vy | output | VCNT_W | Line offset from the window start |

## Verification
The bench builds the block with HCNT_W=9 and VCNT_W=8, the narrowest counters that still hold the largest start values (257 dots and 252 lines). With these widths the saturation points at 511 dots and 255 lines are a few hundred cycles or lines away. The bench sweeps every `hpos` and every `vpos` value and compares the window flags and offsets on every sampled cycle with values computed from the start formulas. It also covers the clamp below 10, both sync polarities, a toggling dot enable, the two-cycle synchroniser delay and both saturation limits.

// File: rtl/osd_window_timer.sv
module osd_window_timer #(
  parameter int HPOS_W   = 6,
  parameter int VPOS_W   = 6,
  parameter int HCNT_W   = 11,
  parameter int VCNT_W   = 10,
  parameter int HPOS_MIN = 10,
  parameter int H_OFS    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dot_en,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              hsync_act_hi,
  input  logic              vsync_act_hi,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [VPOS_W-1:0] vpos,
  output logic              h_active,
  output logic              h_first,
  output logic [HCNT_W-1:0] hx,
  output logic              v_active,
  output logic              v_first,
  output logic [VCNT_W-1:0] vy
);

  localparam logic [HCNT_W-1:0] HMAX = '1;
  localparam logic [VCNT_W-1:0] VMAX = '1;

  logic [1:0]        hs_sync, vs_sync;
  logic              hs_act, vs_act, hs_act_d, hs_rise;
  logic [HCNT_W-1:0] hcnt, hstart;
  logic [VCNT_W-1:0] vcnt, vstart;
  logic [HPOS_W-1:0] hpos_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_sync  <= '0;
      vs_sync  <= '0;
      hs_act_d <= 1'b0;
    end else begin
      hs_sync  <= {hs_sync[0], hsync_in};
      vs_sync  <= {vs_sync[0], vsync_in};
      hs_act_d <= hs_act;
    end

  assign hs_act  = hsync_act_hi ? hs_sync[1] : ~hs_sync[1];
  assign vs_act  = vsync_act_hi ? vs_sync[1] : ~vs_sync[1];
  assign hs_rise = hs_act & ~hs_act_d;

  assign hpos_eff = (hpos < HPOS_W'(HPOS_MIN)) ? HPOS_W'(HPOS_MIN) : hpos;
  assign hstart   = HCNT_W'({hpos_eff, 2'b00}) + HCNT_W'(H_OFS);
  assign vstart   = VCNT_W'({vpos, 2'b00});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      hcnt <= '0;
    else if (!hs_act)
      hcnt <= '0;
    else if (dot_en && hcnt != HMAX)
      hcnt <= hcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      vcnt <= '0;
    else if (vs_act)
      vcnt <= '0;
    else if (hs_rise && vcnt != VMAX)
      vcnt <= vcnt + 1'b1;

  assign h_active = rst_n && hs_act && (hcnt >= hstart);
  assign h_first  = h_active && (hcnt == hstart);
  assign hx       = h_active ? hcnt - hstart : '0;
  assign v_active = rst_n && !vs_act && (vcnt >= vstart);
  assign v_first  = v_active && (vcnt == vstart);
  assign vy       = v_active ? vcnt - vstart : '0;

  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act && dot_en && hcnt != HMAX) |=> (hcnt == $past(hcnt) + 1'b1))
    else $error("hcnt did not step");
  p_hreset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_act |=> (hcnt == '0))
    else $error("hcnt not cleared");
  p_hhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act && !dot_en) |=> $stable(hcnt))
    else $error("hcnt moved without enable");
  p_hsat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act && hcnt == HMAX) |=> (hcnt == HMAX))
    else $error("hcnt wrapped");
  p_hmin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h_active |-> (hcnt >= HCNT_W'(4 * HPOS_MIN + H_OFS)))
    else $error("window before minimum start");
  p_vreset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vs_act |=> (vcnt == '0))
    else $error("vcnt not cleared");
  p_vhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_act && !hs_rise) |=> $stable(vcnt))
    else $error("vcnt moved without line");
  p_vsat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_act && vcnt == VMAX) |=> (vcnt == VMAX))
    else $error("vcnt wrapped");

endmodule

// File: tb/test_osd_window_timer.sv
module test_osd_window_timer;
  localparam int HW = 9;
  localparam int VW = 8;
  localparam int HM = (1 << HW) - 1;
  localparam int VM = (1 << VW) - 1;

  logic clk = 0, rst_n = 0, dot_en = 1;
  logic hsync_in = 0, vsync_in = 0, hsync_act_hi = 1, vsync_act_hi = 1;
  logic [5:0] hpos = 6'd10, vpos = 6'd0;
  logic h_active, h_first, v_active, v_first;
  logic [HW-1:0] hx;
  logic [VW-1:0] vy;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  osd_window_timer #(.HCNT_W(HW), .VCNT_W(VW)) i_osd_window_timer (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .hsync_act_hi(hsync_act_hi), .vsync_act_hi(vsync_act_hi),
    .hpos(hpos), .vpos(vpos), .h_active(h_active), .h_first(h_first), .hx(hx),
    .v_active(v_active), .v_first(v_first), .vy(vy));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int hstart_of(input int hp);
    return 4 * (hp < 10 ? 10 : hp) + 5;
  endfunction

  task automatic hsweep(input logic pol, input int hp, input int len);
    int st, c, ce;
    string req;
    hsync_act_hi = pol; hpos = 6'(hp); hsync_in = ~pol; dot_en = 1;
    repeat (4) step();
    chk("R5 idle h_active", int'(h_active), 0);
    chk("R5 idle hx", int'(hx), 0);
    st = hstart_of(hp);
    req = (pol == 1'b0) ? "R6" : (hp < 10) ? "R4" : "R3";
    hsync_in = pol;
    c = 0;
    for (int k = 1; k <= len; k++) begin
      step();
      c = (k < 2) ? 0 : k - 2;
      if (c > HM) c = HM;
      chk({req, c == HM ? " R10" : "", " h_active"}, int'(h_active), int'(c >= st));
      chk({req, " R2 hx"}, int'(hx), c >= st ? c - st : 0);
      chk({req, " h_first"}, int'(h_first), int'(c == st));
    end
    hsync_in = ~pol;
    step();
    ce = (c + 1 > HM) ? HM : c + 1;
    chk("R1 h_active one edge after release", int'(h_active), int'(ce >= st));
    chk("R1 hx one edge after release", int'(hx), ce >= st ? ce - st : 0);
    step();
    chk("R5 h_active after release", int'(h_active), 0);
    chk("R5 hx after release", int'(hx), 0);
    chk("R5 h_first after release", int'(h_first), 0);
  endtask

  task automatic vrun(input logic vpol, input int vp, input int nl);
    int vs, c;
    string req;
    hsync_act_hi = 1; hsync_in = 0; vsync_act_hi = vpol; vpos = 6'(vp);
    req = (vpol == 1'b0) ? "R6 R7" : "R7";
    vsync_in = vpol;
    repeat (6) step();
    chk("R8 v_active in vsync", int'(v_active), 0);
    chk("R8 vy in vsync", int'(vy), 0);
    vsync_in = ~vpol;
    repeat (4) step();
    vs = 4 * vp;
    for (int i = 0; i <= nl; i++) begin
      if (i > 0) begin
        hsync_in = 1; repeat (3) step();
        hsync_in = 0; repeat (3) step();
      end
      c = (i > VM) ? VM : i;
      chk({req, c == VM ? " R10" : "", " v_active"}, int'(v_active), int'(c >= vs));
      chk({req, " vy"}, int'(vy), c >= vs ? c - vs : 0);
      chk({req, " v_first"}, int'(v_first), int'(c == vs));
    end
    vsync_in = vpol;
    repeat (4) step();
    chk("R8 v_active after vsync", int'(v_active), 0);
    chk("R8 vy after vsync", int'(vy), 0);
    chk("R8 v_first after vsync", int'(v_first), 0);
    vsync_in = ~vpol;
    repeat (4) step();
    chk("R8 vy cleared by vsync", int'(vy), 0);
    chk("R8 v_active cleared by vsync", int'(v_active), int'(vs == 0));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 h_active", int'(h_active), 0);
    chk("R11 h_first", int'(h_first), 0);
    chk("R11 hx", int'(hx), 0);
    chk("R11 v_active", int'(v_active), 0);
    chk("R11 v_first", int'(v_first), 0);
    chk("R11 vy", int'(vy), 0);
    rst_n = 1;
    step();

    for (int hp = 0; hp < 64; hp++) hsweep(1'b1, hp, hstart_of(hp) + 3);
    hsweep(1'b1, 10, 600);
    hsweep(1'b0, 12, 70);
    hsweep(1'b0, 63, 262);
    hsweep(1'b0, 3, 50);

    begin : r9_enable
      int e;
      hsync_act_hi = 1; hpos = 6'd10; hsync_in = 0; dot_en = 1;
      repeat (4) step();
      hsync_in = 1;
      e = 0;
      for (int k = 1; k <= 140; k++) begin
        dot_en = (k % 2 == 0);
        step();
        if (k >= 3 && dot_en) e++;
        chk("R9 hx with gated enable", int'(hx), e >= 45 ? e - 45 : 0);
        chk("R9 h_active with gated enable", int'(h_active), int'(e >= 45));
      end
      dot_en = 1; hsync_in = 0;
      repeat (4) step();
    end

    for (int vp = 0; vp < 64; vp++) vrun(1'b1, vp, 4 * vp + 2);
    vrun(1'b1, 63, 262);
    vrun(1'b0, 5, 24);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule